// File: doc/BRIEF.md
# VM Exit Condition Filter

This block sits next to a processor core that runs guest code. Each time the core reports a guest event, the block decides whether that event must leave guest mode and go to the hypervisor, or whether the guest may handle it. The possible events are an external interrupt, an exception, an I/O port access, an MSR read, an MSR write and a control-register write. The decision for each kind of event comes from its own control bits or bitmap. The hypervisor sets these through a simple word-addressed write port.

The block registers the verdict one cycle after the event. It returns an exit flag, a 4-bit reason code that names the class of event that caused the exit, and an error flag for events whose class is malformed. Saving processor state, decoding instructions and injecting interrupts are left to other logic.

Top module: `exit_filter`

## Requirements
- R1: After reset, all outputs are low and every control bit and bitmap is clear. No event with an in-range index then causes an exit.
- R2: `vld_o` is high in exactly the cycle after a cycle with `evt_valid_i` high. While `vld_o` is low, `exit_o` and `err_o` are low and `reason_o` is 0.
- R3: When control bit 0 (config address 0) is set, every external interrupt (class 1) exits, whatever the guest interrupt-enable flag is.
- R4: When control bit 1 is set and bit 0 is clear, an external interrupt exits only if `evt_if_i` is high.
- R5: For a control-register write (class 6), control bits 2 to 6 enable exits for CR0 to CR4, with the register number given by the event index. A write to a register numbered above 4 always exits.
- R6: The exception bitmap (config address 1) selects exception vectors (class 2). Bit n set means vector n exits. A vector of 32 or more never exits.
- R7: The port bitmap covers ports 0 to 255 (class 3). Port p is stored at config address 2 + p/32, in bit p%32. A port of 256 or more always exits.
- R8: MSR reads (class 4) use the bitmap at addresses 10 and 11. MSR writes (class 5) use the bitmap at addresses 12 and 13. MSR m is stored in word m/32, bit m%32. Read and write are decided independently. An MSR index of 64 or more always exits.
- R9: On an exit, `reason_o` equals the event class code (1 ext interrupt, 2 exception, 3 port, 4 MSR read, 5 MSR write, 6 CR write). On no exit, `reason_o` is 0.
- R10: An event with class 0 (none) or class 7 (unknown) gives no exit and reason 0, with `err_o` high. Valid classes give `err_o` low.
- R11: A configuration write in the same cycle as an event does not affect that event's verdict. It applies from the next event onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| evt_valid_i | input | 1 | Guest event present |
| evt_class_i | input | 3 | Event class code |
| evt_index_i | input | 16 | Vector, port, MSR or CR number |
| evt_if_i | input | 1 | Guest interrupt-enable flag |
| vld_o | output | 1 | Verdict valid |
| exit_o | output | 1 | Event must exit guest mode |
| reason_o | output | 4 | Exit reason code |
| err_o | output | 1 | Malformed event class |

## Verification
The assertions check the parts of the behaviour that do not depend on configuration, on every cycle. These are the one-cycle verdict timing, quiet outputs when idle, the match between the reason code and the exit flag, the error handling for bad classes, and the forced exit for MSR indices out of range. The choice between exit and stay depends on bitmap and control contents that only the hypervisor writes. For that reason, the bench scenarios have to show it: each interrupt mode, single bits at both ends of every bitmap, read and write filtering that differ for one MSR, and a configuration write that lands on the same edge as an event.

// File: rtl/exit_filter_pkg.sv
package exit_filter_pkg;

  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_EXT_INT = 3'd1,
    EV_EXCEPT  = 3'd2,
    EV_PORT    = 3'd3,
    EV_MSR_RD  = 3'd4,
    EV_MSR_WR  = 3'd5,
    EV_CR_WR   = 3'd6,
    EV_BAD     = 3'd7
  } ev_class_e;

  typedef enum logic [3:0] {
    RS_NONE    = 4'd0,
    RS_EXT_INT = 4'd1,
    RS_EXCEPT  = 4'd2,
    RS_PORT    = 4'd3,
    RS_MSR_RD  = 4'd4,
    RS_MSR_WR  = 4'd5,
    RS_CR_WR   = 4'd6
  } exit_reason_e;

  localparam int CTL_EXT_ALL = 0;
  localparam int CTL_EXT_IF  = 1;
  localparam int CTL_CR_BASE = 2;
  localparam int NUM_CR      = 5;
  localparam int CTL_W       = CTL_CR_BASE + NUM_CR;

endpackage

// File: rtl/exit_cfg.sv
module exit_cfg
  import exit_filter_pkg::*;
#(
  parameter int DW        = 32,
  parameter int PORT_BITS = 256,
  parameter int MSR_BITS  = 64,
  parameter int AW        = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [CTL_W-1:0]     ctl_o,
  output logic [DW-1:0]        exc_bm_o,
  output logic [PORT_BITS-1:0] port_bm_o,
  output logic [MSR_BITS-1:0]  msr_rd_bm_o,
  output logic [MSR_BITS-1:0]  msr_wr_bm_o
);
  localparam int PORT_WORDS = PORT_BITS / DW;
  localparam int MSR_WORDS  = MSR_BITS / DW;
  localparam int ADR_CTL    = 0;
  localparam int ADR_EXC    = 1;
  localparam int ADR_PORT   = 2;
  localparam int ADR_MSR_RD = ADR_PORT + PORT_WORDS;
  localparam int ADR_MSR_WR = ADR_MSR_RD + MSR_WORDS;

  logic [CTL_W-1:0] ctl_q;
  logic [DW-1:0]    exc_q;
  logic [DW-1:0]    port_q   [PORT_WORDS];
  logic [DW-1:0]    msr_rd_q [MSR_WORDS];
  logic [DW-1:0]    msr_wr_q [MSR_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      exc_q <= '0;
      for (int w = 0; w < PORT_WORDS; w++) port_q[w] <= '0;
      for (int w = 0; w < MSR_WORDS; w++) begin
        msr_rd_q[w] <= '0;
        msr_wr_q[w] <= '0;
      end
    end else if (we_i) begin
      if (addr_i == AW'(ADR_CTL)) ctl_q <= wdata_i[CTL_W-1:0];
      if (addr_i == AW'(ADR_EXC)) exc_q <= wdata_i;
      for (int w = 0; w < PORT_WORDS; w++)
        if (addr_i == AW'(ADR_PORT + w)) port_q[w] <= wdata_i;
      for (int w = 0; w < MSR_WORDS; w++) begin
        if (addr_i == AW'(ADR_MSR_RD + w)) msr_rd_q[w] <= wdata_i;
        if (addr_i == AW'(ADR_MSR_WR + w)) msr_wr_q[w] <= wdata_i;
      end
    end
  end

  assign ctl_o    = ctl_q;
  assign exc_bm_o = exc_q;

  for (genvar g = 0; g < PORT_WORDS; g++) begin : g_port
    assign port_bm_o[g*DW +: DW] = port_q[g];
  end

  for (genvar g = 0; g < MSR_WORDS; g++) begin : g_msr
    assign msr_rd_bm_o[g*DW +: DW] = msr_rd_q[g];
    assign msr_wr_bm_o[g*DW +: DW] = msr_wr_q[g];
  end

endmodule

// File: rtl/exit_lookup.sv
module exit_lookup
  import exit_filter_pkg::*;
#(
  parameter int DW        = 32,
  parameter int PORT_BITS = 256,
  parameter int MSR_BITS  = 64,
  parameter int IDX_W     = 16
) (
  input  ev_class_e            cls_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 if_i,
  input  logic [CTL_W-1:0]     ctl_i,
  input  logic [DW-1:0]        exc_bm_i,
  input  logic [PORT_BITS-1:0] port_bm_i,
  input  logic [MSR_BITS-1:0]  msr_rd_bm_i,
  input  logic [MSR_BITS-1:0]  msr_wr_bm_i,
  output logic                 hit_o,
  output logic                 err_o,
  output exit_reason_e         reason_o
);
  localparam int EA_W = $clog2(DW);
  localparam int PA_W = $clog2(PORT_BITS);
  localparam int MA_W = $clog2(MSR_BITS);

  logic [31:0] idx_ext;
  logic        exc_in, port_in, msr_in, cr_in, cr_hit;

  assign idx_ext = 32'(idx_i);
  assign exc_in  = idx_ext < 32'(DW);
  assign port_in = idx_ext < 32'(PORT_BITS);
  assign msr_in  = idx_ext < 32'(MSR_BITS);
  assign cr_in   = idx_ext < 32'(NUM_CR);

  always_comb begin
    cr_hit = 1'b0;
    for (int c = 0; c < NUM_CR; c++)
      if (idx_ext == 32'(c)) cr_hit = ctl_i[CTL_CR_BASE + c];
  end

  always_comb begin
    hit_o = 1'b0;
    err_o = 1'b0;
    case (cls_i)
      EV_EXT_INT: hit_o = ctl_i[CTL_EXT_ALL] | (ctl_i[CTL_EXT_IF] & if_i);
      EV_EXCEPT:  hit_o = exc_in  & exc_bm_i[idx_i[EA_W-1:0]];
      EV_PORT:    hit_o = !port_in | port_bm_i[idx_i[PA_W-1:0]];
      EV_MSR_RD:  hit_o = !msr_in  | msr_rd_bm_i[idx_i[MA_W-1:0]];
      EV_MSR_WR:  hit_o = !msr_in  | msr_wr_bm_i[idx_i[MA_W-1:0]];
      EV_CR_WR:   hit_o = !cr_in   | cr_hit;
      default:    err_o = 1'b1;
    endcase
    reason_o = hit_o ? exit_reason_e'({1'b0, cls_i}) : RS_NONE;
  end

endmodule

// File: rtl/exit_filter.sv
module exit_filter
  import exit_filter_pkg::*;
#(
  parameter int DW        = 32,
  parameter int PORT_BITS = 256,
  parameter int MSR_BITS  = 64,
  parameter int IDX_W     = 16,
  parameter int AW        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  input  logic             evt_valid_i,
  input  logic [2:0]       evt_class_i,
  input  logic [IDX_W-1:0] evt_index_i,
  input  logic             evt_if_i,
  output logic             vld_o,
  output logic             exit_o,
  output logic [3:0]       reason_o,
  output logic             err_o
);
  logic [CTL_W-1:0]     ctl;
  logic [DW-1:0]        exc_bm;
  logic [PORT_BITS-1:0] port_bm;
  logic [MSR_BITS-1:0]  msr_rd_bm, msr_wr_bm;
  logic                 hit, bad;
  exit_reason_e         reason;

  exit_cfg #(.DW(DW), .PORT_BITS(PORT_BITS), .MSR_BITS(MSR_BITS), .AW(AW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .ctl_o       (ctl),
    .exc_bm_o    (exc_bm),
    .port_bm_o   (port_bm),
    .msr_rd_bm_o (msr_rd_bm),
    .msr_wr_bm_o (msr_wr_bm)
  );

  exit_lookup #(.DW(DW), .PORT_BITS(PORT_BITS), .MSR_BITS(MSR_BITS), .IDX_W(IDX_W)) u_lookup (
    .cls_i       (ev_class_e'(evt_class_i)),
    .idx_i       (evt_index_i),
    .if_i        (evt_if_i),
    .ctl_i       (ctl),
    .exc_bm_i    (exc_bm),
    .port_bm_i   (port_bm),
    .msr_rd_bm_i (msr_rd_bm),
    .msr_wr_bm_i (msr_wr_bm),
    .hit_o       (hit),
    .err_o       (bad),
    .reason_o    (reason)
  );

  // verdict uses pre-write config: cfg flops update on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      exit_o   <= 1'b0;
      reason_o <= '0;
      err_o    <= 1'b0;
    end else begin
      vld_o    <= evt_valid_i;
      exit_o   <= evt_valid_i & hit;
      reason_o <= evt_valid_i ? 4'(reason) : 4'd0;
      err_o    <= evt_valid_i & bad;
    end
  end

endmodule

// File: rtl/exit_filter_chk.sv
module exit_filter_chk #(
  parameter int MSR_BITS = 64,
  parameter int IDX_W    = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_valid_i,
  input logic [2:0]       evt_class_i,
  input logic [IDX_W-1:0] evt_index_i,
  input logic             vld_o,
  input logic             exit_o,
  input logic [3:0]       reason_o,
  input logic             err_o
);
  p_vld_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i |=> vld_o);
  p_vld_drops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> !vld_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (!exit_o && !err_o && reason_o == 4'd0));
  p_reason_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |-> (reason_o >= 4'd1 && reason_o <= 4'd6));
  p_reason_stay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exit_o |-> reason_o == 4'd0);
  p_bad_class_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && (evt_class_i == 3'd0 || evt_class_i == 3'd7)) |=> (err_o && !exit_o));
  p_good_class_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_class_i != 3'd0 && evt_class_i != 3'd7) |=> !err_o);
  p_msr_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && (evt_class_i == 3'd4 || evt_class_i == 3'd5)
      && 32'(evt_index_i) >= 32'(MSR_BITS))
    |=> (exit_o && reason_o == {1'b0, $past(evt_class_i)}));
endmodule

bind exit_filter exit_filter_chk #(.MSR_BITS(MSR_BITS), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_exit_filter.sv
module sim_exit_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_class = '0;
  logic [15:0] evt_index = '0;
  logic        evt_if = 1'b0;
  logic        vld, ex, err;
  logic [3:0]  reason;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exit_filter u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .evt_valid_i(evt_valid), .evt_class_i(evt_class), .evt_index_i(evt_index),
    .evt_if_i(evt_if),
    .vld_o(vld), .exit_o(ex), .reason_o(reason), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one event, sample verdict at the following negedge
  task automatic send(input logic [2:0] c, input logic [15:0] i, input logic f);
    @(negedge clk);
    evt_valid = 1'b1; evt_class = c; evt_index = i; evt_if = f;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic expect_evt(input string tag, input logic [2:0] c, input logic [15:0] i,
                            input logic f, input logic exp_exit);
    send(c, i, f);
    chk({tag, " vld R2"}, vld, 1);
    chk({tag, " exit"}, ex, exp_exit);
    chk({tag, " reason R9"}, reason, exp_exit ? {1'b0, c} : 4'd0);
    chk({tag, " err R10"}, err, 0);
  endtask

  task automatic t_reset();
    chk("R1 vld", vld, 0);
    chk("R1 exit", ex, 0);
    chk("R1 reason", reason, 0);
    chk("R1 err", err, 0);
    expect_evt("R1 ext", 3'd1, 16'd0, 1'b1, 0);
    expect_evt("R1 exc", 3'd2, 16'd14, 1'b0, 0);
    expect_evt("R1 port", 3'd3, 16'd5, 1'b0, 0);
    expect_evt("R1 msrrd", 3'd4, 16'd3, 1'b0, 0);
    expect_evt("R1 msrwr", 3'd5, 16'd63, 1'b0, 0);
    expect_evt("R1 cr", 3'd6, 16'd0, 1'b0, 0);
  endtask

  task automatic t_timing();
    send(3'd3, 16'd1, 1'b0);
    chk("R2 vld after event", vld, 1);
    @(negedge clk);
    chk("R2 vld idle", vld, 0);
    chk("R2 exit idle", ex, 0);
  endtask

  task automatic t_ext_int();
    cfg_write(4'd0, 32'h1);
    expect_evt("R3 all if0", 3'd1, 16'd0, 1'b0, 1);
    expect_evt("R3 all if1", 3'd1, 16'd0, 1'b1, 1);
    cfg_write(4'd0, 32'h2);
    expect_evt("R4 ifmode if0", 3'd1, 16'd0, 1'b0, 0);
    expect_evt("R4 ifmode if1", 3'd1, 16'd0, 1'b1, 1);
    cfg_write(4'd0, 32'h0);
  endtask

  task automatic t_cr();
    cfg_write(4'd0, 32'h1 << (2 + 3));
    expect_evt("R5 cr3", 3'd6, 16'd3, 1'b0, 1);
    expect_evt("R5 cr0", 3'd6, 16'd0, 1'b0, 0);
    expect_evt("R5 cr4", 3'd6, 16'd4, 1'b0, 0);
    expect_evt("R5 cr7", 3'd6, 16'd7, 1'b0, 1);
    expect_evt("R5 ext unaffected", 3'd1, 16'd0, 1'b1, 0);
    cfg_write(4'd0, 32'h0);
  endtask

  task automatic t_exc();
    cfg_write(4'd1, (32'h1 << 14) | 32'h8000_0000);
    expect_evt("R6 vec14", 3'd2, 16'd14, 1'b0, 1);
    expect_evt("R6 vec13", 3'd2, 16'd13, 1'b0, 0);
    expect_evt("R6 vec31", 3'd2, 16'd31, 1'b0, 1);
    expect_evt("R6 vec46", 3'd2, 16'd46, 1'b0, 0);
  endtask

  task automatic t_port();
    cfg_write(4'd5, 32'h1);          // port 0x60
    cfg_write(4'd9, 32'h8000_0000);  // port 255
    expect_evt("R7 p60", 3'd3, 16'h60, 1'b0, 1);
    expect_evt("R7 p61", 3'd3, 16'h61, 1'b0, 0);
    expect_evt("R7 p255", 3'd3, 16'd255, 1'b0, 1);
    expect_evt("R7 p0", 3'd3, 16'd0, 1'b0, 0);
    expect_evt("R7 p300", 3'd3, 16'h300, 1'b0, 1);
  endtask

  task automatic t_msr();
    cfg_write(4'd10, 32'h1 << 10);   // read MSR 10
    cfg_write(4'd13, 32'h1 << 8);    // write MSR 40
    expect_evt("R8 rd10", 3'd4, 16'd10, 1'b0, 1);
    expect_evt("R8 wr10", 3'd5, 16'd10, 1'b0, 0);
    expect_evt("R8 wr40", 3'd5, 16'd40, 1'b0, 1);
    expect_evt("R8 rd40", 3'd4, 16'd40, 1'b0, 0);
    expect_evt("R8 rd100", 3'd4, 16'd100, 1'b0, 1);
    expect_evt("R8 wr64", 3'd5, 16'd64, 1'b0, 1);
  endtask

  task automatic t_bad_class();
    cfg_write(4'd0, 32'h7f);
    send(3'd0, 16'd0, 1'b1);
    chk("R10 none exit", ex, 0);
    chk("R10 none reason", reason, 0);
    chk("R10 none err", err, 1);
    send(3'd7, 16'd3, 1'b1);
    chk("R10 unknown exit", ex, 0);
    chk("R10 unknown reason", reason, 0);
    chk("R10 unknown err", err, 1);
    cfg_write(4'd0, 32'h0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'h1;
    evt_valid = 1'b1; evt_class = 3'd1; evt_index = '0; evt_if = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; evt_valid = 1'b0;
    chk("R11 same-edge uses old cfg", ex, 0);
    expect_evt("R11 next event new cfg", 3'd1, 16'd0, 1'b0, 1);
    cfg_write(4'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_ext_int();
    t_cr();
    t_exc();
    t_port();
    t_msr();
    t_bad_class();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule